// File: doc/BRIEF.md
# Multi-Queue Core Dispatcher

This block takes commands from several command queues filled by the host and hands them out to a pool of interchangeable encoder cores and to a DMA engine. Each command has one of four kinds: start a job on a core, copy from device memory to host memory, copy from host memory to device memory, or a fence that waits for earlier work to finish. A run command names no core. The dispatcher gives it to the lowest-numbered core that is idle. Cores hold no state from one job to the next, so any idle core can take any job.

The queues are served round-robin, and each cycle one command at most leaves a queue. Only the head of a queue can be issued. A head that cannot proceed is passed over: a run command with no idle core, a copy while the DMA engine is not ready, or a fence whose queue still has work in flight. The dispatcher then serves the next queue that can proceed. Each queue counts its own outstanding work. Core completions come in as a per-core done vector, and the dispatcher uses the queue it recorded for each core to credit the completion to the right queue. DMA completions carry their queue index. A fence blocks only its own queue. Work may finish in any order, but a fence never completes before the work queued ahead of it.

Top module: `jobq_dispatch`

## Requirements
- R1: While reset is held and in the first cycle after it, no core start, DMA issue or fence completion is signalled, and no queue reports full.
- R2: A run command (opcode 0 in the two most significant bits of the command word, job address in the remaining bits) starts the lowest-indexed idle core. The start is a one-hot pulse on core_start, and core_addr carries the job address.
- R3: A core that has been started is not started again until its bit in core_done has pulsed. With every core busy, run commands stay in their queue.
- R4: A copy command (opcode 1 = device to host, dma_dir 0; opcode 2 = host to device, dma_dir 1) is issued to the DMA engine only in a cycle where dma_ready is high. It carries its address and the index of its queue.
- R5: A fence command (opcode 3) completes only when every run and copy issued earlier from its queue has retired. A retirement is a core_done pulse on the core that ran the job, or a dma_done pulse tagged with the queue. A completed fence pulses wait_done with wait_q set to the queue.
- R6: A pending fence stalls only its own queue. Other queues keep issuing.
- R7: At most one command is issued per cycle. After a command is issued from queue q, the search starts at queue q+1 and wraps around. Queues whose head cannot proceed are skipped.
- R8: q_full[q] is high while queue q holds DEPTH commands. A push to a full queue is dropped.
- R9: Commands leave a queue in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push a command into the queue given by push_q |
| push_q | input | QW | Target queue index |
| push_cmd | input | ADDR_W+2 | Command word: opcode in the two MSBs, address below |
| q_full | output | NQ | Per-queue full flag |
| core_start | output | NCORE | One-hot start pulse to a core |
| core_addr | output | ADDR_W | Job address for the started core |
| core_done | input | NCORE | Per-core completion pulse |
| dma_ready | input | 1 | DMA engine can take a copy this cycle |
| dma_issue | output | 1 | Copy issue pulse |
| dma_dir | output | 1 | 0 = device to host, 1 = host to device |
| dma_addr | output | ADDR_W | Copy descriptor address |
| dma_q | output | QW | Queue the copy came from |
| dma_done | input | 1 | Copy completion pulse |
| dma_done_q | input | QW | Queue of the completed copy |
| wait_done | output | 1 | Fence completion pulse |
| wait_q | output | QW | Queue of the completed fence |

## Verification
The bench fills the core pool completely and checks that a further run command waits and then lands on the one core released. A design that ignores busy cores would start a core twice, and one that picks the wrong free core would report the wrong index. Fences are tested against both a core job and a copy. A fence that fires early shows up as a wait_done before the matching completion. A fence that blocks the whole dispatcher shows up when a run in another queue fails to start. Full-queue drops, the rotation order across three loaded queues, and the skipping of a run head when no core is free are each compared against orders and counts worked out in the bench.

// File: rtl/jobq_pkg.sv
package jobq_pkg;
  typedef enum logic [1:0] {
    OP_RUN  = 2'd0,
    OP_D2H  = 2'd1,
    OP_H2D  = 2'd2,
    OP_WAIT = 2'd3
  } jq_op_e;
endpackage

// File: rtl/jobq_fifo.sv
module jobq_fifo #(
  parameter int WIDTH = 34,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
    end
  end

  assign rd_data = mem[rptr[AW-1:0]];
  assign empty   = (wptr == rptr);
  assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
endmodule

// File: rtl/jobq_rr_pick.sv
module jobq_rr_pick #(
  parameter int NQ = 4,
  parameter int QW = 2
) (
  input  logic [NQ-1:0] req,
  input  logic [QW-1:0] ptr,
  output logic          gnt_any,
  output logic [QW-1:0] gnt_q
);
  always_comb begin
    int idx;
    gnt_any = 1'b0;
    gnt_q   = '0;
    for (int i = 0; i < NQ; i++) begin
      idx = int'(ptr) + i;
      if (idx >= NQ) idx = idx - NQ;
      if (!gnt_any && req[idx]) begin
        gnt_any = 1'b1;
        gnt_q   = QW'(idx);
      end
    end
  end
endmodule

// File: rtl/jobq_pool.sv
module jobq_pool #(
  parameter int NQ    = 4,
  parameter int NCORE = 10,
  parameter int QW    = 2,
  parameter int CW    = 4,
  parameter int RW    = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_en,
  input  logic [QW-1:0]          start_q,
  input  logic [NCORE-1:0]       done,
  output logic                   idle_any,
  output logic [CW-1:0]          idle_idx,
  output logic [NQ-1:0][RW-1:0]  ret_cnt
);
  logic [NCORE-1:0]         busy;
  logic [NCORE-1:0][QW-1:0] owner;
  logic [NCORE-1:0]         start_vec;

  always_comb begin
    idle_any = 1'b0;
    idle_idx = '0;
    for (int c = NCORE - 1; c >= 0; c--) begin
      if (!busy[c]) begin
        idle_any = 1'b1;
        idle_idx = CW'(c);
      end
    end
  end

  assign start_vec = start_en ? (NCORE'(1) << idle_idx) : '0;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      ret_cnt[q] = '0;
      for (int c = 0; c < NCORE; c++) begin
        if (done[c] && busy[c] && owner[c] == QW'(q))
          ret_cnt[q] = ret_cnt[q] + RW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else     busy <= (busy & ~done) | start_vec;
  end

  always_ff @(posedge clk) begin
    if (start_en) owner[idle_idx] <= start_q;
  end
endmodule

// File: rtl/jobq_dispatch.sv
module jobq_dispatch
  import jobq_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int NCORE  = 10,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int CMD_W = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [QW-1:0]     push_q,
  input  logic [CMD_W-1:0]  push_cmd,
  output logic [NQ-1:0]     q_full,
  output logic [NCORE-1:0]  core_start,
  output logic [ADDR_W-1:0] core_addr,
  input  logic [NCORE-1:0]  core_done,
  input  logic              dma_ready,
  output logic              dma_issue,
  output logic              dma_dir,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [QW-1:0]     dma_q,
  input  logic              dma_done,
  input  logic [QW-1:0]     dma_done_q,
  output logic              wait_done,
  output logic [QW-1:0]     wait_q
);
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1;
  localparam int RW = $clog2(NCORE + 1);

  logic [NQ-1:0]            fifo_empty, fifo_full, fifo_wr, fifo_rd, elig;
  logic [NQ-1:0][CMD_W-1:0] head;
  logic [NQ-1:0][CNT_W-1:0] outst;
  logic [NQ-1:0][RW-1:0]    core_ret;
  logic                     gnt_any, idle_any;
  logic [QW-1:0]            gnt_q, rr_ptr;
  logic [CW-1:0]            idle_idx;
  logic [CMD_W-1:0]         sel_cmd;
  jq_op_e                   sel_op;
  logic                     issue_run, issue_copy, issue_wait;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    jq_op_e hop;

    assign fifo_wr[g] = push_valid && (push_q == QW'(g)) && !fifo_full[g];
    assign fifo_rd[g] = gnt_any && (gnt_q == QW'(g));

    jobq_fifo #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (fifo_wr[g]),
      .wr_data (push_cmd),
      .rd_en   (fifo_rd[g]),
      .rd_data (head[g]),
      .empty   (fifo_empty[g]),
      .full    (fifo_full[g])
    );

    assign hop = jq_op_e'(head[g][CMD_W-1 -: 2]);

    always_comb begin
      case (hop)
        OP_RUN:  elig[g] = !fifo_empty[g] && idle_any;
        OP_D2H,
        OP_H2D:  elig[g] = !fifo_empty[g] && dma_ready;
        default: elig[g] = !fifo_empty[g] && (outst[g] == '0);
      endcase
    end

    logic inc_g, dmad_g;
    assign inc_g  = fifo_rd[g] && (sel_op != OP_WAIT);
    assign dmad_g = dma_done && (dma_done_q == QW'(g));

    always_ff @(posedge clk) begin
      if (rst) outst[g] <= '0;
      else     outst[g] <= outst[g] + CNT_W'(inc_g) - CNT_W'(core_ret[g]) - CNT_W'(dmad_g);
    end
  end

  assign q_full = fifo_full;

  jobq_rr_pick #(.NQ(NQ), .QW(QW)) u_pick (
    .req     (elig),
    .ptr     (rr_ptr),
    .gnt_any (gnt_any),
    .gnt_q   (gnt_q)
  );

  assign sel_cmd    = head[gnt_q];
  assign sel_op     = jq_op_e'(sel_cmd[CMD_W-1 -: 2]);
  assign issue_run  = gnt_any && (sel_op == OP_RUN);
  assign issue_copy = gnt_any && (sel_op == OP_D2H || sel_op == OP_H2D);
  assign issue_wait = gnt_any && (sel_op == OP_WAIT);

  jobq_pool #(.NQ(NQ), .NCORE(NCORE), .QW(QW), .CW(CW), .RW(RW)) u_pool (
    .clk      (clk),
    .rst      (rst),
    .start_en (issue_run),
    .start_q  (gnt_q),
    .done     (core_done),
    .idle_any (idle_any),
    .idle_idx (idle_idx),
    .ret_cnt  (core_ret)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr     <= '0;
      core_start <= '0;
      core_addr  <= '0;
      dma_issue  <= 1'b0;
      dma_dir    <= 1'b0;
      dma_addr   <= '0;
      dma_q      <= '0;
      wait_done  <= 1'b0;
      wait_q     <= '0;
    end else begin
      core_start <= issue_run ? (NCORE'(1) << idle_idx) : '0;
      dma_issue  <= issue_copy;
      wait_done  <= issue_wait;
      if (issue_run) core_addr <= sel_cmd[ADDR_W-1:0];
      if (issue_copy) begin
        dma_dir  <= (sel_op == OP_H2D);
        dma_addr <= sel_cmd[ADDR_W-1:0];
        dma_q    <= gnt_q;
      end
      if (issue_wait) wait_q <= gnt_q;
      if (gnt_any) rr_ptr <= (gnt_q == QW'(NQ - 1)) ? '0 : gnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/jobq_dispatch_chk.sv
module jobq_dispatch_chk #(
  parameter int NCORE = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [NCORE-1:0] core_start,
  input logic [NCORE-1:0] core_done,
  input logic             dma_ready,
  input logic             dma_issue,
  input logic             wait_done
);
  logic [NCORE-1:0] shadow_busy;

  always_ff @(posedge clk) begin
    if (rst) shadow_busy <= '0;
    else     shadow_busy <= (shadow_busy | core_start) & ~core_done;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (core_start == '0 && !dma_issue && !wait_done)); // R1
  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(core_start)); // R2
  AST_NO_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    (core_start & shadow_busy) == '0); // R3
  AST_DMA_READY: assert property (@(posedge clk) disable iff (rst)
    dma_issue |-> $past(dma_ready)); // R4
  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (rst)
    $countones({(core_start != '0), dma_issue, wait_done}) <= 1); // R7
endmodule

bind jobq_dispatch jobq_dispatch_chk #(.NCORE(NCORE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .core_start (core_start),
  .core_done  (core_done),
  .dma_ready  (dma_ready),
  .dma_issue  (dma_issue),
  .wait_done  (wait_done)
);

// File: tb/jobq_dispatch_test.sv
module jobq_dispatch_test;
  localparam int NQ = 3, NCORE = 3, DEPTH = 4, AW = 8;
  localparam int QW = 2, CMD_W = AW + 2;

  logic clk = 1'b0, rst = 1'b1;
  logic push_valid = 1'b0;
  logic [QW-1:0] push_q = '0;
  logic [CMD_W-1:0] push_cmd = '0;
  logic [NQ-1:0] q_full;
  logic [NCORE-1:0] core_start, core_done = '0;
  logic [AW-1:0] core_addr, dma_addr;
  logic dma_ready = 1'b0, dma_issue, dma_dir, dma_done = 1'b0, wait_done;
  logic [QW-1:0] dma_q, dma_done_q = '0, wait_q;

  int total = 0, bad = 0;
  int n_start = 0, n_dma = 0, n_wait = 0;
  int st_core [32];
  int st_addr [32];
  int dm_q [32];
  int dm_dir [32];
  int dm_addr [32];
  int wt_q [32];
  bit finished = 0;

  always #10 clk = ~clk;

  jobq_dispatch #(.NQ(NQ), .NCORE(NCORE), .DEPTH(DEPTH), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_q(push_q), .push_cmd(push_cmd),
    .q_full(q_full), .core_start(core_start), .core_addr(core_addr), .core_done(core_done),
    .dma_ready(dma_ready), .dma_issue(dma_issue), .dma_dir(dma_dir), .dma_addr(dma_addr),
    .dma_q(dma_q), .dma_done(dma_done), .dma_done_q(dma_done_q),
    .wait_done(wait_done), .wait_q(wait_q));

  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < NCORE; c++)
        if (core_start[c] && n_start < 32) begin
          st_core[n_start] = c; st_addr[n_start] = int'(core_addr); n_start++;
        end
      if (dma_issue && n_dma < 32) begin
        dm_q[n_dma] = int'(dma_q); dm_dir[n_dma] = int'(dma_dir);
        dm_addr[n_dma] = int'(dma_addr); n_dma++;
      end
      if (wait_done && n_wait < 32) begin
        wt_q[n_wait] = int'(wait_q); n_wait++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; dma_ready = 1'b0; core_done = '0; dma_done = 1'b0; push_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; n_start = 0; n_dma = 0; n_wait = 0;
  endtask

  task automatic push(input int q, input int op, input int addr);
    push_valid = 1'b1; push_q = QW'(q); push_cmd = {op[1:0], addr[AW-1:0]};
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done_core(input int c);
    core_done = NCORE'(1) << c;
    @(negedge clk);
    core_done = '0;
  endtask

  task automatic done_dma(input int q);
    dma_done = 1'b1; dma_done_q = QW'(q);
    @(negedge clk);
    dma_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check(q_full == '0 && core_start == '0 && !dma_issue && !wait_done, "R1 outputs in reset", int'(q_full), 0);
    do_reset();
    idle(3);
    check(n_start == 0 && n_dma == 0 && n_wait == 0 && q_full == '0, "R1 idle after reset",
          n_start + n_dma + n_wait, 0);

    // R2 / R3: fill the pool, hold the overflow run, release core 1
    for (int i = 0; i < 4; i++) push(0, 0, 16 + i);
    idle(6);
    check(n_start == 3, "R3 pool full holds run", n_start, 3);
    for (int i = 0; i < 3; i++) begin
      check(st_core[i] == i, "R2 lowest idle core", st_core[i], i);
      check(st_addr[i] == 16 + i, "R2 job address", st_addr[i], 16 + i);
    end
    done_core(1);
    idle(4);
    check(n_start == 4, "R3 start after release", n_start, 4);
    check(st_core[3] == 1, "R2 released core reused", st_core[3], 1);
    check(st_addr[3] == 19, "R2 held job address", st_addr[3], 19);

    // R4: copies wait for dma_ready, direction from opcode
    do_reset();
    push(1, 1, 8'h21);
    push(2, 2, 8'h32);
    idle(5);
    check(n_dma == 0, "R4 no issue without ready", n_dma, 0);
    dma_ready = 1'b1;
    idle(4);
    check(n_dma == 2, "R4 copies issued", n_dma, 2);
    check(dm_q[0] == 1 && dm_dir[0] == 0 && dm_addr[0] == 8'h21, "R4 d2h copy", dm_addr[0], 8'h21);
    check(dm_q[1] == 2 && dm_dir[1] == 1 && dm_addr[1] == 8'h32, "R4 h2d copy", dm_addr[1], 8'h32);

    // R5: fence behind a core job, then behind a copy
    do_reset();
    dma_ready = 1'b1;
    push(2, 0, 8'h40);
    push(2, 3, 0);
    idle(6);
    check(n_start == 1 && n_wait == 0, "R5 fence held by core job", n_wait, 0);
    done_core(0);
    idle(4);
    check(n_wait == 1 && wt_q[0] == 2, "R5 fence after core done", n_wait, 1);
    push(1, 1, 8'h50);
    push(1, 3, 0);
    idle(5);
    check(n_dma == 1 && n_wait == 1, "R5 fence held by copy", n_wait, 1);
    done_dma(1);
    idle(4);
    check(n_wait == 2 && wt_q[1] == 1, "R5 fence after dma done", n_wait, 2);

    // R6 / R9: fence stalls only its own queue
    do_reset();
    push(0, 0, 8'h60);
    push(0, 3, 0);
    push(0, 0, 8'h61);
    push(1, 0, 8'h70);
    idle(8);
    check(n_start == 2 && n_wait == 0, "R6 other queue proceeds", n_start, 2);
    check(st_addr[1] == 8'h70 && st_core[1] == 1, "R6 other queue job", st_addr[1], 8'h70);
    done_core(0);
    idle(5);
    check(n_wait == 1 && wt_q[0] == 0, "R5 fence released", n_wait, 1);
    check(n_start == 3 && st_addr[2] == 8'h61 && st_core[2] == 0, "R9 job behind fence", st_addr[2], 8'h61);

    // R7: rotation over three loaded queues
    do_reset();
    for (int q = 0; q < 3; q++) begin
      push(q, 1, 8'h80 + 16 * q);
      push(q, 1, 8'h81 + 16 * q);
    end
    dma_ready = 1'b1;
    idle(10);
    check(n_dma == 6, "R7 all copies issued", n_dma, 6);
    for (int i = 0; i < 6; i++)
      check(dm_q[i] == i % 3 && dm_addr[i] == 8'h80 + 16 * (i % 3) + i / 3,
            "R7 round-robin order", dm_addr[i], 8'h80 + 16 * (i % 3) + i / 3);

    // R7: run head skipped when no core is idle
    do_reset();
    for (int i = 1; i <= 4; i++) push(0, 0, i);
    push(1, 1, 8'hB1);
    push(2, 2, 8'hC2);
    idle(4);
    dma_ready = 1'b1;
    idle(4);
    check(n_dma == 2 && n_start == 3, "R7 copies pass blocked run", n_dma, 2);
    done_core(2);
    idle(4);
    check(n_start == 4 && st_core[3] == 2 && st_addr[3] == 4, "R7 blocked run later", st_core[3], 2);

    // R8 / R9: full queue drops pushes, order preserved
    do_reset();
    for (int i = 0; i < 5; i++) push(0, 1, i);
    idle(2);
    check(q_full == 3'b001, "R8 full flag", int'(q_full), 1);
    dma_ready = 1'b1;
    idle(8);
    check(n_dma == 4, "R8 extra push dropped", n_dma, 4);
    for (int i = 0; i < 4; i++)
      check(dm_addr[i] == i, "R9 queue order", dm_addr[i], i);
    check(q_full == '0, "R8 full cleared", int'(q_full), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule